// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block carries out one single-byte register write or register read on a remote I2C device. It does the work by driving the byte-wide register port of an I2C master controller. The host presents a 7-bit device address, an 8-bit register index, a direction flag and a write byte, then raises a request. The sequencer runs a fixed program against the controller. It enables the controller, programs the SCL timing, arms the interrupt-enable bits and starts the bus. It then polls the status register and answers each wait or data-empty event with the next data byte or control code, clearing each flag as it is consumed. Reads use a repeated start followed by a switch into receive mode.

When a status poll shows lost arbitration or a missing acknowledge, the sequencer runs a recovery program. Recovery stops the bus, waits for the controller to go idle and restarts the whole transaction. After a bounded number of recoveries the transaction ends with an error. A bounded poll on the controller's busy flag turns a hung bus into a timeout error. The controller is reached through a strobe/ready access port with at most one access in flight.

Top module: `i2c_reg_sequencer`

## Requirements
- R1: A transaction opens with five controller writes in this order: control = 0x80, SCL-low period (offset 0x10), SCL-high period (offset 0x14), interrupt enable (offset 0x0C) = previous value OR 0x07, control = 0x94.
- R2: The SCL low/high periods come from `strap_i`: 0 gives 0x07/0x01, 1 gives 0x09/0x02, 2 gives 0x0B/0x03 and 3 gives 0x0E/0x05. `variant_i` high overrides the strap and gives 0x15/0x07.
- R3: A write proceeds as follows:
  - Once status bit 0x01 (data empty) is seen, the sequencer clears interrupt-enable bit 0x01 and writes {dev,0} to data (offset 0x00).
  - On each later status bit 0x02 (wait), it writes the register index, then the data byte, then control = 0x90.
  - Each of these is followed by a status (offset 0x08) write that zeroes only the wait bit.
- R4: A read proceeds as follows:
  - After the index, control = 0x94 is written, wait is cleared and IE bit 0x01 is set again.
  - On data empty, IE bit 0x01 is cleared and {dev,1} is written.
  - On wait, control = 0x81 is written. On the next wait, control = 0xC0 is written.
  - On the final data empty, IE bit 0x01 is cleared and the data register is read into `rdata_o`.
- R5: After the stop, the status register is polled until bit 0x10 (busy) reads zero. Control is then written 0x00 and the sequencer reports done without error.
- R6: Arbitration lost (status bit 0x08) seen in a poll does the following:
  - Clears that bit.
  - Writes dummy byte 0x52 if the first address byte was awaited.
  - Waits for wait, then writes control = 0x90 (0xC0 in the stop-after-read step) and clears wait.
  - Polls busy clear, writes control 0x00 and restarts from R1.
- R7: A missing acknowledge (status bit 0x04) writes the stop code, clears IE bits 0x02 and 0x01, clears only bit 0x04, polls busy clear, writes control 0x00 and restarts from R1.
- R8: Every recovery bumps a per-transaction count. The recovery that takes the count past RETRY_MAX (default 2, so the third) ends the transaction with `err_o` instead of a restart.
- R9: If the busy bit still reads one on POLL_LIMIT consecutive busy polls, the transaction ends at once with `done_o`, `err_o` and `timeout_o` high and no further controller access.
- R10: Handshake:
  - A request is accepted only when idle and is answered by a one-cycle `ack_o`.
  - Acceptance clears `done_o`, `err_o`, `timeout_o` and `rdata_o`.
  - These outputs then hold their final values until the next request is accepted.
- R11: `acc_strobe_o` is a one-cycle pulse. No new strobe is raised before `acc_ready_i` has answered the previous one, and no strobe is raised while `done_o` is high.
- R12: The error checks are made at every poll except the final data read. When arbitration lost and missing acknowledge show in the same status read, only the arbitration-lost recovery runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transaction request, level |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| dev_i | input | 7 | Target device address |
| reg_i | input | 8 | Target register index |
| wdata_i | input | 8 | Byte to write |
| strap_i | input | 2 | SCL timing selection |
| variant_i | input | 1 | Forces the fixed SCL timing pair |
| ack_o | output | 1 | One-cycle request acceptance |
| done_o | output | 1 | Transaction finished, held |
| err_o | output | 1 | Transaction failed, held |
| timeout_o | output | 1 | Busy poll bound exceeded, held |
| rdata_o | output | 8 | Byte read, held |
| acc_strobe_o | output | 1 | Controller access strobe |
| acc_we_o | output | 1 | Access is a write |
| acc_addr_o | output | ADDR_W | Controller register offset |
| acc_wdata_o | output | 8 | Controller write data |
| acc_rdata_i | input | 8 | Controller read data |
| acc_ready_i | input | 1 | Access completed |

## Verification
Lost arbitration and a missing acknowledge can both be reported by the controller in the same status read, and each calls for a different recovery program. The bench's controller model raises both flags together in response to the start code. The outcome is judged from the recorded controller write stream: it must contain the dummy byte and a single stop/idle pair before the restart. That shows that only the arbitration path ran and that it counted as one retry. Retry exhaustion is probed on both sides of the limit, with two failures that recover and three that fail.

// File: rtl/seq_pkg.sv
package seq_pkg;

   // controller register offsets
   localparam logic [7:0] OFF_DATA = 8'h00;
   localparam logic [7:0] OFF_CTRL = 8'h04;
   localparam logic [7:0] OFF_STAT = 8'h08;
   localparam logic [7:0] OFF_IEN  = 8'h0C;
   localparam logic [7:0] OFF_SCLL = 8'h10;
   localparam logic [7:0] OFF_SCLH = 8'h14;

   // status flags
   localparam logic [7:0] ST_BUSY = 8'h10;
   localparam logic [7:0] ST_AL   = 8'h08;
   localparam logic [7:0] ST_NACK = 8'h04;
   localparam logic [7:0] ST_WAIT = 8'h02;
   localparam logic [7:0] ST_DTE  = 8'h01;

   // interrupt enables
   localparam logic [7:0] IE_ALL  = 8'h07;
   localparam logic [7:0] IE_WAIT = 8'h02;
   localparam logic [7:0] IE_DTE  = 8'h01;

   // control codes
   localparam logic [7:0] CT_EN     = 8'h80;
   localparam logic [7:0] CT_START  = 8'h94;
   localparam logic [7:0] CT_STOP   = 8'h90;
   localparam logic [7:0] CT_RX     = 8'h81;
   localparam logic [7:0] CT_STOPRD = 8'hC0;
   localparam logic [7:0] CT_OFF    = 8'h00;

   localparam logic [7:0] FILLER_BYTE = 8'h52;

   typedef enum logic [3:0] {
      PH_ADDR, PH_REG, PH_WDATA, PH_STOP, PH_RSTART,
      PH_ADDR_RD, PH_SWRX, PH_STOPRD, PH_READ
   } phase_t;

   typedef enum logic [4:0] {
      S_IDLE, S_EN, S_SCLL, S_SCLH, S_IEN, S_GO, S_POLL, S_ACT,
      S_AL_CLR, S_AL_FILL, S_AL_WPOLL, S_AL_STOP, S_AL_WCLR,
      S_NK_STOP, S_NK_IEN, S_NK_CLR, S_BPOLL, S_OFF
   } seq_state_t;

   typedef struct packed {
      logic       we;
      logic [7:0] off;
      logic [7:0] wdata;
   } acc_op_t;

endpackage

// File: rtl/seq_scl_select.sv
module seq_scl_select #(
   parameter int PERIOD_W = 8
) (
   input  logic [1:0]          strap_i,
   input  logic                variant_i,
   output logic [PERIOD_W-1:0] lo_o,
   output logic [PERIOD_W-1:0] hi_o
);
   if (PERIOD_W < 5) begin : g_width_bad
      $error("seq_scl_select: PERIOD_W must hold 0x15");
   end

   always_comb begin
      if (variant_i) begin
         lo_o = PERIOD_W'(8'h15);
         hi_o = PERIOD_W'(8'h07);
      end else begin
         case (strap_i)
            2'd0:    begin lo_o = PERIOD_W'(8'h07); hi_o = PERIOD_W'(8'h01); end
            2'd1:    begin lo_o = PERIOD_W'(8'h09); hi_o = PERIOD_W'(8'h02); end
            2'd2:    begin lo_o = PERIOD_W'(8'h0B); hi_o = PERIOD_W'(8'h03); end
            default: begin lo_o = PERIOD_W'(8'h0E); hi_o = PERIOD_W'(8'h05); end
         endcase
      end
   end
endmodule

// File: rtl/seq_poll_guard.sv
module seq_poll_guard #(
   parameter int LIMIT = 500_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic bump_i,
   output logic last_o
);
   localparam int CNT_W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_limit_bad
      $error("seq_poll_guard: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (bump_i) cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q >= CNT_W'(LIMIT - 1));
endmodule

// File: rtl/seq_retry_budget.sv
module seq_retry_budget #(
   parameter int RETRY_MAX = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic bump_i,
   output logic spent_o
);
   localparam int CNT_W = $clog2(RETRY_MAX + 2);

   if (RETRY_MAX < 0) begin : g_retry_bad
      $error("seq_retry_budget: RETRY_MAX must not be negative");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (bump_i) cnt_q <= cnt_q + 1'b1;
   end

   // the next recovery would push the count past the limit
   assign spent_o = (cnt_q >= CNT_W'(RETRY_MAX));
endmodule

// File: rtl/i2c_reg_sequencer.sv
module i2c_reg_sequencer
   import seq_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int POLL_LIMIT = 500_000_000,
   parameter int RETRY_MAX  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              rd_i,
   input  logic [6:0]        dev_i,
   input  logic [7:0]        reg_i,
   input  logic [7:0]        wdata_i,
   input  logic [1:0]        strap_i,
   input  logic              variant_i,
   output logic              ack_o,
   output logic              done_o,
   output logic              err_o,
   output logic              timeout_o,
   output logic [7:0]        rdata_o,
   output logic              acc_strobe_o,
   output logic              acc_we_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [7:0]        acc_wdata_o,
   input  logic [7:0]        acc_rdata_i,
   input  logic              acc_ready_i
);
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_addr_bad
      $error("i2c_reg_sequencer: ADDR_W must be 5..8");
   end

   seq_state_t state_q;
   phase_t     phase_q, act_next;
   logic [1:0] step_q;
   logic       pend_q, rec_q, rd_q;
   logic [6:0] dev_q;
   logic [7:0] reg_q, wd_q, ie_q, stat_q;
   acc_op_t    op, act;
   logic       act_last;
   logic [7:0] scl_lo, scl_hi, stop_code;
   logic       fin, guard_last, budget_spent, need_dte, chk_err;

   seq_scl_select #(.PERIOD_W(8)) u_scl (
      .strap_i(strap_i), .variant_i(variant_i), .lo_o(scl_lo), .hi_o(scl_hi));

   seq_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q != S_BPOLL),
      .bump_i(fin && state_q == S_BPOLL && (acc_rdata_i & ST_BUSY) != 8'h00),
      .last_o(guard_last));

   seq_retry_budget #(.RETRY_MAX(RETRY_MAX)) u_budget (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q == S_IDLE),
      .bump_i(fin && state_q == S_OFF && rec_q && !budget_spent),
      .spent_o(budget_spent));

   assign fin       = pend_q && acc_ready_i;
   assign stop_code = (phase_q == PH_STOPRD) ? CT_STOPRD : CT_STOP;
   assign need_dte  = (phase_q == PH_ADDR) || (phase_q == PH_ADDR_RD) || (phase_q == PH_READ);
   assign chk_err   = (phase_q != PH_READ);

   // per-phase action program
   always_comb begin
      act      = '{1'b1, OFF_STAT, stat_q & ~ST_WAIT};
      act_last = (step_q == 2'd1);
      act_next = phase_q;
      case (phase_q)
         PH_ADDR: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_IEN, ie_q & ~IE_DTE};
            else                act = '{1'b1, OFF_DATA, {dev_q, 1'b0}};
            act_next = PH_REG;
         end
         PH_REG: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_DATA, reg_q};
            act_next = rd_q ? PH_RSTART : PH_WDATA;
         end
         PH_WDATA: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_DATA, wd_q};
            act_next = PH_STOP;
         end
         PH_STOP: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_CTRL, CT_STOP};
         end
         PH_RSTART: begin
            if (step_q == 2'd0)      act = '{1'b1, OFF_CTRL, CT_START};
            else if (step_q == 2'd2) act = '{1'b1, OFF_IEN, ie_q | IE_DTE};
            act_last = (step_q == 2'd2);
            act_next = PH_ADDR_RD;
         end
         PH_ADDR_RD: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_IEN, ie_q & ~IE_DTE};
            else                act = '{1'b1, OFF_DATA, {dev_q, 1'b1}};
            act_next = PH_SWRX;
         end
         PH_SWRX: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_CTRL, CT_RX};
            act_next = PH_STOPRD;
         end
         PH_STOPRD: begin
            if (step_q == 2'd0)      act = '{1'b1, OFF_CTRL, CT_STOPRD};
            else if (step_q == 2'd2) act = '{1'b1, OFF_IEN, ie_q | IE_DTE};
            act_last = (step_q == 2'd2);
            act_next = PH_READ;
         end
         default: begin
            if (step_q == 2'd0) act = '{1'b1, OFF_IEN, ie_q & ~IE_DTE};
            else                act = '{1'b0, OFF_DATA, 8'h00};
         end
      endcase
   end

   // access selected by the sequencer state
   always_comb begin
      op = '{1'b0, OFF_STAT, 8'h00};
      case (state_q)
         S_EN:      op = '{1'b1, OFF_CTRL, CT_EN};
         S_SCLL:    op = '{1'b1, OFF_SCLL, scl_lo};
         S_SCLH:    op = '{1'b1, OFF_SCLH, scl_hi};
         S_IEN:     op = '{1'b1, OFF_IEN, ie_q | IE_ALL};
         S_GO:      op = '{1'b1, OFF_CTRL, CT_START};
         S_ACT:     op = act;
         S_AL_CLR:  op = '{1'b1, OFF_STAT, stat_q & ~ST_AL};
         S_AL_FILL: op = '{1'b1, OFF_DATA, FILLER_BYTE};
         S_AL_STOP: op = '{1'b1, OFF_CTRL, stop_code};
         S_AL_WCLR: op = '{1'b1, OFF_STAT, stat_q & ~ST_WAIT};
         S_NK_STOP: op = '{1'b1, OFF_CTRL, stop_code};
         S_NK_IEN:  op = '{1'b1, OFF_IEN, ie_q & ~(IE_WAIT | IE_DTE)};
         S_NK_CLR:  op = '{1'b1, OFF_STAT, stat_q & ~ST_NACK};
         S_OFF:     op = '{1'b1, OFF_CTRL, CT_OFF};
         default:   op = '{1'b0, OFF_STAT, 8'h00};
      endcase
   end

   assign acc_strobe_o = (state_q != S_IDLE) && !pend_q;
   assign acc_we_o     = op.we;
   assign acc_addr_o   = op.off[ADDR_W-1:0];
   assign acc_wdata_o  = op.wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;  phase_q <= PH_ADDR;  step_q <= 2'd0;
         pend_q  <= 1'b0;    rec_q   <= 1'b0;     rd_q   <= 1'b0;
         dev_q   <= '0;      reg_q   <= '0;       wd_q   <= '0;
         ie_q    <= '0;      stat_q  <= '0;
         ack_o   <= 1'b0;    done_o  <= 1'b0;     err_o  <= 1'b0;
         timeout_o <= 1'b0;  rdata_o <= '0;
      end else begin
         ack_o <= 1'b0;
         if (acc_strobe_o) begin
            pend_q <= 1'b1;
            if (op.we && op.off == OFF_IEN) ie_q <= op.wdata;
         end
         if (fin) begin
            pend_q <= 1'b0;
            if (!op.we && op.off == OFF_STAT) stat_q <= acc_rdata_i;
         end
         if (state_q == S_IDLE) begin
            if (req_i) begin
               ack_o <= 1'b1;  done_o <= 1'b0;  err_o <= 1'b0;
               timeout_o <= 1'b0;  rdata_o <= '0;
               rd_q <= rd_i;  dev_q <= dev_i;  reg_q <= reg_i;  wd_q <= wdata_i;
               rec_q <= 1'b0;  state_q <= S_EN;
            end
         end else if (fin) begin
            case (state_q)
               S_EN:   state_q <= S_SCLL;
               S_SCLL: state_q <= S_SCLH;
               S_SCLH: state_q <= S_IEN;
               S_IEN:  state_q <= S_GO;
               S_GO: begin
                  phase_q <= PH_ADDR;  step_q <= 2'd0;  state_q <= S_POLL;
               end
               S_POLL: begin
                  if (chk_err && (acc_rdata_i & ST_AL) != 8'h00)        state_q <= S_AL_CLR;
                  else if (chk_err && (acc_rdata_i & ST_NACK) != 8'h00) state_q <= S_NK_STOP;
                  else if ((acc_rdata_i & (need_dte ? ST_DTE : ST_WAIT)) != 8'h00) begin
                     step_q <= 2'd0;  state_q <= S_ACT;
                  end
               end
               S_ACT: begin
                  if (!op.we) rdata_o <= acc_rdata_i;
                  if (act_last) begin
                     step_q  <= 2'd0;  phase_q <= act_next;
                     state_q <= (phase_q == PH_STOP || phase_q == PH_READ) ? S_BPOLL : S_POLL;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
               S_AL_CLR:   state_q <= (phase_q == PH_ADDR) ? S_AL_FILL : S_AL_WPOLL;
               S_AL_FILL:  state_q <= S_AL_WPOLL;
               S_AL_WPOLL: if ((acc_rdata_i & ST_WAIT) != 8'h00) state_q <= S_AL_STOP;
               S_AL_STOP:  state_q <= S_AL_WCLR;
               S_AL_WCLR:  begin rec_q <= 1'b1; state_q <= S_BPOLL; end
               S_NK_STOP:  state_q <= S_NK_IEN;
               S_NK_IEN:   state_q <= S_NK_CLR;
               S_NK_CLR:   begin rec_q <= 1'b1; state_q <= S_BPOLL; end
               S_BPOLL: begin
                  if ((acc_rdata_i & ST_BUSY) == 8'h00) state_q <= S_OFF;
                  else if (guard_last) begin
                     done_o <= 1'b1;  err_o <= 1'b1;  timeout_o <= 1'b1;
                     state_q <= S_IDLE;
                  end
               end
               S_OFF: begin
                  if (rec_q && budget_spent) begin
                     done_o <= 1'b1;  err_o <= 1'b1;  state_q <= S_IDLE;
                  end else if (rec_q) begin
                     rec_q <= 1'b0;  state_q <= S_EN;
                  end else begin
                     done_o <= 1'b1;  state_q <= S_IDLE;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
   input logic clk,
   input logic rst_n,
   input logic req_i,
   input logic ack_o,
   input logic done_o,
   input logic err_o,
   input logic timeout_o,
   input logic acc_strobe_o
);
   // R11
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_strobe_o |=> !acc_strobe_o);

   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !acc_strobe_o);

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !done_o && !err_o && !timeout_o);

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !req_i |=> done_o);

   // R8
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R9
   timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> err_o && done_o);
endmodule

bind i2c_reg_sequencer seq_checker u_seq_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .done_o(done_o),
   .err_o(err_o), .timeout_o(timeout_o), .acc_strobe_o(acc_strobe_o));

// File: tb/i2c_reg_sequencer_test.sv
module i2c_reg_sequencer_test;
   localparam int LIM = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, rd = 1'b0, variant = 1'b0;
   logic [6:0] dev = '0;
   logic [7:0] rix = '0, wd = '0;
   logic [1:0] strap = '0;
   logic ack, done, err, tmo, stb, we, rdy;
   logic [7:0] rdat, awd, ardt;
   logic [4:0] aad;

   int checks = 0, errors = 0, cyc = 0;

   always #4 clk = ~clk;

   i2c_reg_sequencer #(.ADDR_W(5), .POLL_LIMIT(LIM), .RETRY_MAX(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .rd_i(rd), .dev_i(dev), .reg_i(rix),
      .wdata_i(wd), .strap_i(strap), .variant_i(variant), .ack_o(ack),
      .done_o(done), .err_o(err), .timeout_o(tmo), .rdata_o(rdat),
      .acc_strobe_o(stb), .acc_we_o(we), .acc_addr_o(aad), .acc_wdata_o(awd),
      .acc_rdata_i(ardt), .acc_ready_i(rdy));

   // ---------------- controller model ----------------
   logic [7:0] m_stat = 0, m_data = 0, rd_val = 0;
   int ev_cnt = 0, bz_cnt = 0, inj_al = 0, inj_nack = 0, byte_idx = 0;
   int st_bad = 0, proto_bad = 0, wn = 0;
   logic [7:0] ev_bits = 0;
   logic intx = 0, rx = 0, rx_last = 0, both = 0, hold_busy = 0, out_q = 0;
   logic [15:0] wlog [0:127];

   initial rdy = 1'b0;
   initial ardt = 8'h00;

   always @(posedge clk) begin : model
      logic [7:0] ns;
      ns = m_stat;
      rdy <= stb;
      out_q <= stb;
      if (stb && out_q) proto_bad <= proto_bad + 1;
      if (ev_cnt > 0) begin
         ev_cnt <= ev_cnt - 1;
         if (ev_cnt == 1) begin
            ns = ns | ev_bits;
            if (rx_last && ev_bits[0]) m_data <= rd_val;
         end
      end
      if (bz_cnt > 0) begin
         bz_cnt <= bz_cnt - 1;
         if (bz_cnt == 1 && !hold_busy) ns = ns & ~8'h10;
      end
      if (stb) begin
         ardt <= (aad == 5'h08) ? m_stat : (aad == 5'h00) ? m_data : 8'h00;
         if (we) begin
            if (aad != 5'h08 && wn < 128) begin
               wlog[wn] <= {3'b000, aad, awd};
               wn <= wn + 1;
            end
            case (aad)
               5'h00: begin
                  ns = ns & ~8'h01;
                  byte_idx <= byte_idx + 1;
                  ev_cnt <= 3;
                  if (inj_nack > 0 && byte_idx == 0) begin
                     ev_bits <= 8'h04; inj_nack <= inj_nack - 1;
                  end else ev_bits <= 8'h02;
               end
               5'h04: begin
                  if (awd == 8'h94) begin
                     ev_cnt <= 3;
                     if (!intx) begin
                        intx <= 1'b1; ns = ns | 8'h10; byte_idx <= 0;
                        if (inj_al > 0) begin
                           ev_bits <= both ? 8'h0E : 8'h0A; inj_al <= inj_al - 1;
                        end else ev_bits <= 8'h01;
                     end else ev_bits <= 8'h01;
                  end else if (awd == 8'h81) rx <= 1'b1;
                  else if (awd == 8'hC0) begin rx_last <= 1'b1; bz_cnt <= 8; end
                  else if (awd == 8'h90) bz_cnt <= 8;
                  else if (awd == 8'h00) begin
                     ns = 8'h00; intx <= 1'b0; rx <= 1'b0; rx_last <= 1'b0;
                     ev_cnt <= 0; bz_cnt <= 0;
                  end
               end
               5'h08: begin
                  if ((awd[3:0] & ~m_stat[3:0]) != 4'h0) st_bad <= st_bad + 1;
                  ns[3:0] = ns[3:0] & awd[3:0];
                  if (m_stat[1] && !awd[1]) begin
                     if (rx_last) begin ev_cnt <= 3; ev_bits <= 8'h01; end
                     else if (rx) begin ev_cnt <= 3; ev_bits <= 8'h02; end
                  end
               end
               default: ;
            endcase
         end
      end
      m_stat <= ns;
   end

   // ---------------- bench helpers ----------------
   logic [15:0] expv [0:127];
   int en = 0;

   task automatic check(input logic ok, input string req_tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp_v);
      end
   endtask

   task automatic push(input logic [7:0] off, input logic [7:0] v);
      expv[en] = {off, v};
      en++;
   endtask

   task automatic push_open(input logic [7:0] lo, input logic [7:0] hi);
      push(8'h04, 8'h80); push(8'h10, lo); push(8'h14, hi);
      push(8'h0C, 8'h07); push(8'h04, 8'h94);
   endtask

   task automatic push_wr_tail(input logic [6:0] d, input logic [7:0] r, input logic [7:0] w);
      push(8'h0C, 8'h06); push(8'h00, {d, 1'b0}); push(8'h00, r);
      push(8'h00, w); push(8'h04, 8'h90); push(8'h04, 8'h00);
   endtask

   task automatic cmp_log(input string req_tag);
      int bad = 0;
      check(wn == en, req_tag, wn, en);
      for (int i = 0; i < en && i < wn; i++) begin
         if (wlog[i] != expv[i] && bad == 0) begin
            bad = 1;
            check(1'b0, req_tag, wlog[i], expv[i]);
         end
      end
      if (bad == 0) check(1'b1, req_tag, 0, 0);
   endtask

   function automatic int count_ctrl(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < wn; i++) if (wlog[i] == {8'h04, v}) n++;
      return n;
   endfunction

   task automatic run_txn(input logic r, input logic [6:0] d, input logic [7:0] ri, input logic [7:0] w);
      int t;
      @(negedge clk);
      wn = 0; en = 0;
      rd = r; dev = d; rix = ri; wd = w; req = 1'b1;
      t = 0;
      while (!ack && t < 50) begin @(negedge clk); t++; end
      req = 1'b0;
      t = 0;
      while (!done && t < 4000) begin @(negedge clk); t++; end
      check(done == 1'b1, "R10 done reached", done, 1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      check(done == 0 && err == 0 && tmo == 0, "R10 reset flags", {done, err, tmo}, 0);
      check(stb == 0 && ack == 0, "R11 reset quiet", {stb, ack}, 0);
   endtask

   task automatic t_write;
      strap = 2'd0; variant = 0;
      run_txn(1'b0, 7'h2A, 8'h13, 8'h5C);
      push_open(8'h07, 8'h01); push_wr_tail(7'h2A, 8'h13, 8'h5C);
      cmp_log("R1 R3 R5 write program");
      check(err == 0, "R5 no error", err, 0);
      check(st_bad == 0, "R3 flag clear only", st_bad, 0);
   endtask

   task automatic t_read;
      rd_val = 8'hA5;
      run_txn(1'b1, 7'h31, 8'h40, 8'h00);
      push_open(8'h07, 8'h01);
      push(8'h0C, 8'h06); push(8'h00, 8'h62); push(8'h00, 8'h40);
      push(8'h04, 8'h94); push(8'h0C, 8'h07); push(8'h0C, 8'h06);
      push(8'h00, 8'h63); push(8'h04, 8'h81); push(8'h04, 8'hC0);
      push(8'h0C, 8'h07); push(8'h0C, 8'h06); push(8'h04, 8'h00);
      cmp_log("R4 read program");
      check(rdat == 8'hA5, "R4 read data", rdat, 8'hA5);
      check(err == 0, "R4 no error", err, 0);
   endtask

   task automatic t_hold;
      repeat (20) @(negedge clk);
      check(done == 1 && rdat == 8'hA5 && ack == 0, "R10 outputs held", rdat, 8'hA5);
   endtask

   task automatic t_straps;
      logic [7:0] los [4] = '{8'h07, 8'h09, 8'h0B, 8'h0E};
      logic [7:0] his [4] = '{8'h01, 8'h02, 8'h03, 8'h05};
      for (int s = 1; s < 5; s++) begin
         strap = (s == 4) ? 2'd1 : 2'(s);
         variant = (s == 4);
         run_txn(1'b0, 7'h10, 8'h01, 8'h02);
         if (s == 4) check(wlog[1][7:0] == 8'h15 && wlog[2][7:0] == 8'h07,
                           "R2 variant periods", {wlog[1][7:0], wlog[2][7:0]}, 16'h1507);
         else check(wlog[1][7:0] == los[s] && wlog[2][7:0] == his[s],
                    "R2 strap periods", {wlog[1][7:0], wlog[2][7:0]}, {los[s], his[s]});
      end
      strap = 2'd0; variant = 0;
   endtask

   task automatic t_nack_once;
      inj_nack = 1;
      run_txn(1'b0, 7'h2A, 8'h13, 8'h5C);
      push_open(8'h07, 8'h01);
      push(8'h0C, 8'h06); push(8'h00, 8'h54); push(8'h04, 8'h90);
      push(8'h0C, 8'h04); push(8'h04, 8'h00);
      push_open(8'h07, 8'h01); push_wr_tail(7'h2A, 8'h13, 8'h5C);
      cmp_log("R7 nack recovery program");
      check(err == 0, "R7 recovered", err, 0);
   endtask

   task automatic t_al(input logic with_nack, input string tag);
      inj_al = 1; both = with_nack;
      run_txn(1'b0, 7'h2A, 8'h13, 8'h5C);
      push_open(8'h07, 8'h01);
      push(8'h00, 8'h52); push(8'h04, 8'h90); push(8'h04, 8'h00);
      push_open(8'h07, 8'h01); push_wr_tail(7'h2A, 8'h13, 8'h5C);
      cmp_log(tag);
      check(err == 0 && count_ctrl(8'h94) == 2, tag, count_ctrl(8'h94), 2);
      both = 0;
   endtask

   task automatic t_retry;
      inj_nack = 2;
      run_txn(1'b0, 7'h11, 8'h22, 8'h33);
      check(err == 0 && count_ctrl(8'h94) == 3, "R8 two recoveries succeed", err, 0);
      inj_nack = 3;
      run_txn(1'b0, 7'h11, 8'h22, 8'h33);
      check(err == 1 && tmo == 0, "R8 third recovery fails", err, 1);
      check(count_ctrl(8'h94) == 3, "R8 no fourth start", count_ctrl(8'h94), 3);
      check(wlog[wn-1] == 16'h0400, "R8 controller idled", wlog[wn-1], 16'h0400);
   endtask

   task automatic t_timeout;
      hold_busy = 1;
      run_txn(1'b0, 7'h05, 8'h06, 8'h07);
      check(err == 1 && tmo == 1, "R9 timeout reported", {err, tmo}, 2'b11);
      check(wlog[wn-1] == 16'h0490, "R9 no idle write", wlog[wn-1], 16'h0490);
      repeat (10) @(negedge clk);
      check(stb == 0, "R9 no further access", stb, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write();
      t_read();
      t_hold();
      t_straps();
      t_nack_once();
      t_al(1'b0, "R6 arbitration recovery");
      t_al(1'b1, "R12 both flags take arbitration path");
      t_retry();
      check(proto_bad == 0, "R11 single outstanding access", proto_bad, 0);
      t_timeout();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule